// File: doc/BRIEF.md
# Tail-Pointer Descriptor Ring Fetcher

This block is the fetch engine of one DMA channel. It reads fixed-size descriptors from a ring in memory and passes them on. Software sets the ring base address and the ring size. It then makes descriptors available by moving a tail pointer. The engine owns every descriptor from its current position up to, but not including, the tail. Descriptors carry no ownership bit. The current position is the only bookkeeping, and software can read it back at any time.

Each descriptor is four 32-bit words. The engine reads them over a simple request/acknowledge memory port and assembles them into one 128-bit word. It offers that word downstream over a valid/ready port. When the current position reaches the tail, the engine suspends and raises a one-cycle interrupt pulse. A tail write that puts new work ahead of the current position restarts it with no other command. When the engine passes the last entry of the ring, it returns to the base address on its own.

Top module: `dring_fetch`

## Requirements
- R1: After reset, `cur_ptr` is 0 and `running`, `mem_req`, `desc_valid` and `suspend_irq` are all low.
- R2: Register writes are selected by `reg_wr_sel` as follows:
  - 0 sets the ring base address. Its low 4 bits are dropped.
  - 1 sets the index of the last ring entry, which is the entry count minus one.
  - 2 sets the tail address.
  - 3 is the control register. Bit 0 enables the engine.
  
  `cur_ptr` always equals base + 16 × current index.
- R3: A fetch issues four reads, at `cur_ptr`, +4, +8 and +12. Each read holds `mem_req` and `mem_addr` steady until the cycle in which `mem_ack` is high. `mem_rdata` is taken in that cycle.
- R4: The assembled descriptor places word k (read at +4k) in bits 32k+31..32k of `desc_data`. `desc_valid` and `desc_data` stay steady until `desc_ready` is high. `cur_ptr` advances only at that acceptance.
- R5: While enabled, the engine keeps fetching as long as the current index differs from the tail index, (tail − base)/16. It stops with the current index equal to the tail index.
- R6: After the entry at the last index, the current index returns to 0.
- R7: A tail write that makes the tail index differ from the current index restarts a suspended engine. This includes a tail that has wrapped below the current address. `mem_req` is high in the cycle after the write.
- R8: A tail write equal to the current address leaves the engine suspended, starts no read and raises no interrupt.
- R9: Writes to base and to the last index are ignored while the engine is active (enabled or not yet stopped). They take effect while it is disabled. Disabling returns the current index to 0.
- R10: `suspend_irq` is high for exactly one cycle on each entry into suspend. This includes enabling the engine with no work pending.
- R11: `running` is high while a descriptor is being fetched or offered. It is low when the engine is suspended or disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select (0 base, 1 last index, 2 tail, 3 control) |
| reg_wr_data | input | ADDR_W | Register write data |
| cur_ptr | output | ADDR_W | Address of the current descriptor |
| running | output | 1 | Engine is fetching or offering a descriptor |
| suspend_irq | output | 1 | One-cycle pulse on entry into suspend |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory read address |
| mem_ack | input | 1 | Memory acknowledge; read data valid |
| mem_rdata | input | 32 | Memory read data |
| desc_valid | output | 1 | Assembled descriptor available |
| desc_data | output | 128 | Assembled descriptor |
| desc_ready | input | 1 | Consumer accepts the descriptor |

## Verification
Timing depends on which register the stimulus passes through:
- **Tail write.** It is sampled at one rising edge and `mem_req` is high in the cycle right after.
- **Enable write.** It passes through the control register, so the suspend pulse comes one edge later again.
- **Base write.** `cur_ptr` follows the base register in the cycle after the write.
- **Pointer advance.** `cur_ptr` moves at the edge where the descriptor is accepted.

The bench drives every input on the falling edge and checks one cycle after each write. Its monitor samples 1 ns after the falling edge, so acceptances, acknowledges and pulses are seen exactly as the next rising edge will see them. Runs of work are judged only after `running` has dropped and two further cycles have passed. By then the interrupt pulse of that entry into suspend has been counted.

// File: rtl/dring_pkg.sv
package dring_pkg;

   localparam int DESC_WORDS = 4;
   localparam int WORD_W     = 32;
   localparam int DESC_W     = DESC_WORDS * WORD_W;
   localparam int DESC_SHIFT = 4;   // log2 of descriptor size in bytes

   typedef enum logic [1:0] {
      SEL_BASE = 2'd0,
      SEL_LAST = 2'd1,
      SEL_TAIL = 2'd2,
      SEL_CTRL = 2'd3
   } dr_sel_e;

   typedef enum logic [1:0] {
      ST_OFF   = 2'd0,
      ST_FETCH = 2'd1,
      ST_OFFER = 2'd2,
      ST_SUSP  = 2'd3
   } dr_state_e;

endpackage

// File: rtl/dring_regs.sv
module dring_regs
   import dring_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic              cfg_lock,
   output logic [ADDR_W-1:0] base_addr,
   output logic [IDX_W-1:0]  ring_last,
   output logic [ADDR_W-1:0] tail_next,
   output logic              enable
);

   logic [ADDR_W-1:0] tail_q;
   logic              wr_base, wr_last, wr_tail, wr_ctrl;

   assign wr_base = wr_en && (wr_sel == SEL_BASE) && !cfg_lock;
   assign wr_last = wr_en && (wr_sel == SEL_LAST) && !cfg_lock;
   assign wr_tail = wr_en && (wr_sel == SEL_TAIL);
   assign wr_ctrl = wr_en && (wr_sel == SEL_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_addr <= '0;
         ring_last <= '0;
         tail_q    <= '0;
         enable    <= 1'b0;
      end else begin
         if (wr_base) base_addr <= {wr_data[ADDR_W-1:DESC_SHIFT], {DESC_SHIFT{1'b0}}};
         if (wr_last) ring_last <= wr_data[IDX_W-1:0];
         if (wr_tail) tail_q    <= wr_data;
         if (wr_ctrl) enable    <= wr_data[0];
      end
   end

   // tail as seen after this cycle's write, so a same-cycle write is not missed
   assign tail_next = wr_tail ? wr_data : tail_q;

   a_r9_base_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_BASE && cfg_lock) |=> $stable(base_addr));

   a_r9_last_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_LAST && cfg_lock) |=> $stable(ring_last));

   a_r2_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      base_addr[DESC_SHIFT-1:0] == '0);

endmodule

// File: rtl/dring_ptr.sv
module dring_ptr
   import dring_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [IDX_W-1:0]  ring_last,
   input  logic [ADDR_W-1:0] tail_next,
   input  logic              clear,
   input  logic              advance,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              pend_now,
   output logic              pend_adv
);

   logic [IDX_W-1:0]  cur_idx, nxt_idx, tail_idx;
   logic [ADDR_W-1:0] tail_off;

   // ring-index space: the tail is reduced to an entry number relative to base
   assign tail_off = tail_next - base_addr;
   assign tail_idx = IDX_W'(tail_off >> DESC_SHIFT);

   assign nxt_idx  = (cur_idx == ring_last) ? '0 : cur_idx + IDX_W'(1);
   assign cur_addr = base_addr + ADDR_W'({cur_idx, {DESC_SHIFT{1'b0}}});

   assign pend_now = (tail_idx != cur_idx);
   assign pend_adv = (tail_idx != nxt_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cur_idx <= '0;
      else if (clear)   cur_idx <= '0;
      else if (advance) cur_idx <= nxt_idx;
   end

   a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !clear && cur_idx == ring_last) |=> cur_idx == '0);

   a_r4_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!advance && !clear) |=> $stable(cur_idx));

   a_r6_idx_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !clear) |=> cur_idx <= ring_last);

endmodule

// File: rtl/dring_seq.sv
module dring_seq
   import dring_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              pend_now,
   input  logic              pend_adv,
   input  logic [ADDR_W-1:0] cur_addr,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              desc_valid,
   output logic [DESC_W-1:0] desc_data,
   input  logic              desc_ready,
   output logic              advance,
   output logic              clear,
   output logic              cfg_lock,
   output logic              running,
   output logic              suspend_irq
);

   localparam int WCNT_W = $clog2(DESC_WORDS);
   localparam logic [WCNT_W-1:0] WLAST = WCNT_W'(DESC_WORDS - 1);

   dr_state_e         state_q, state_d;
   logic [WCNT_W-1:0] wcnt_q;
   logic              enter_susp;
   logic              word_take;

   always_comb begin
      state_d    = state_q;
      enter_susp = 1'b0;
      if (!enable) begin
         state_d = ST_OFF;
      end else begin
         case (state_q)
            ST_OFF: begin
               if (pend_now) state_d = ST_FETCH;
               else begin
                  state_d    = ST_SUSP;
                  enter_susp = 1'b1;
               end
            end
            ST_FETCH: if (mem_ack && wcnt_q == WLAST) state_d = ST_OFFER;
            ST_OFFER: begin
               if (desc_ready) begin
                  if (pend_adv) state_d = ST_FETCH;
                  else begin
                     state_d    = ST_SUSP;
                     enter_susp = 1'b1;
                  end
               end
            end
            ST_SUSP: if (pend_now) state_d = ST_FETCH;
            default: state_d = ST_OFF;
         endcase
      end
   end

   assign word_take = (state_q == ST_FETCH) && mem_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_OFF;
         wcnt_q      <= '0;
         suspend_irq <= 1'b0;
      end else begin
         state_q     <= state_d;
         suspend_irq <= enter_susp;
         if (state_q != ST_FETCH) wcnt_q <= '0;
         else if (mem_ack)        wcnt_q <= wcnt_q + WCNT_W'(1);
      end
   end

   // one capture register per descriptor word
   for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
      logic [WORD_W-1:0] w_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                        w_q <= '0;
         else if (word_take && wcnt_q == WCNT_W'(g))        w_q <= mem_rdata;
      end
      assign desc_data[g*WORD_W +: WORD_W] = w_q;
   end

   assign mem_req    = (state_q == ST_FETCH);
   assign mem_addr   = cur_addr + ADDR_W'({wcnt_q, 2'b00});
   assign desc_valid = (state_q == ST_OFFER);
   assign advance    = (state_q == ST_OFFER) && desc_ready;
   assign clear      = (state_q == ST_OFF);
   assign cfg_lock   = (state_q != ST_OFF);
   assign running    = (state_q == ST_FETCH) || (state_q == ST_OFFER);

   a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n || !enable)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

   a_r4_offer_hold: assert property (@(posedge clk) disable iff (!rst_n || !enable)
      (desc_valid && !desc_ready) |=> (desc_valid && $stable(desc_data)));

   a_r3_offer_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(desc_valid) |-> $past(mem_ack));

   a_r10_irq_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
      suspend_irq |-> (state_q == ST_SUSP && $past(state_q) != ST_SUSP));

   a_r10_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
      suspend_irq |=> !suspend_irq);

   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (!mem_req && !desc_valid));

endmodule

// File: rtl/dring_fetch.sv
module dring_fetch
   import dring_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [1:0]        reg_wr_sel,
   input  logic [ADDR_W-1:0] reg_wr_data,
   output logic [ADDR_W-1:0] cur_ptr,
   output logic              running,
   output logic              suspend_irq,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              desc_valid,
   output logic [DESC_W-1:0] desc_data,
   input  logic              desc_ready
);

   if (IDX_W < 1 || ADDR_W < IDX_W + DESC_SHIFT + 1) begin : g_bad_width
      $error("dring_fetch: ADDR_W must exceed IDX_W + DESC_SHIFT");
   end
   if (DESC_WORDS != 4 || (1 << DESC_SHIFT) != DESC_WORDS * WORD_W / 8) begin : g_bad_desc
      $error("dring_fetch: descriptor geometry inconsistent");
   end

   logic [ADDR_W-1:0] base_addr, tail_next, cur_addr;
   logic [IDX_W-1:0]  ring_last;
   logic              enable, cfg_lock, clear, advance, pend_now, pend_adv;

   dring_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr_en),
      .wr_sel    (reg_wr_sel),
      .wr_data   (reg_wr_data),
      .cfg_lock  (cfg_lock),
      .base_addr (base_addr),
      .ring_last (ring_last),
      .tail_next (tail_next),
      .enable    (enable)
   );

   dring_ptr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .base_addr (base_addr),
      .ring_last (ring_last),
      .tail_next (tail_next),
      .clear     (clear),
      .advance   (advance),
      .cur_addr  (cur_addr),
      .pend_now  (pend_now),
      .pend_adv  (pend_adv)
   );

   dring_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable      (enable),
      .pend_now    (pend_now),
      .pend_adv    (pend_adv),
      .cur_addr    (cur_addr),
      .mem_req     (mem_req),
      .mem_addr    (mem_addr),
      .mem_ack     (mem_ack),
      .mem_rdata   (mem_rdata),
      .desc_valid  (desc_valid),
      .desc_data   (desc_data),
      .desc_ready  (desc_ready),
      .advance     (advance),
      .clear       (clear),
      .cfg_lock    (cfg_lock),
      .running     (running),
      .suspend_irq (suspend_irq)
   );

   assign cur_ptr = cur_addr;

   a_r7_no_stall_with_work: assert property (@(posedge clk) disable iff (!rst_n || !enable)
      (cfg_lock && !running && pend_now && !suspend_irq) |=> running);

endmodule

// File: tb/dring_fetch_bench.sv
`timescale 1ns/1ps
module dring_fetch_bench;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_wr_en = 1'b0;
   logic [1:0]   reg_wr_sel = 2'd0;
   logic [31:0]  reg_wr_data = '0;
   logic [31:0]  cur_ptr;
   logic         running, suspend_irq, mem_req, desc_valid;
   logic [31:0]  mem_addr;
   logic         mem_ack = 1'b0;
   logic [31:0]  mem_rdata = '0;
   logic [127:0] desc_data;
   logic         desc_ready = 1'b1;
   logic         ack_en = 1'b1;

   int checks = 0;
   int errors = 0;
   int irq_cnt = 0;
   int acc_cnt = 0;
   int ack_n = 0;
   logic [31:0] ack_log [16];
   logic irq_prev = 1'b0;
   bit   done = 1'b0;

   always #5 clk = ~clk;

   dring_fetch u_dring_fetch (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
      .cur_ptr(cur_ptr), .running(running), .suspend_irq(suspend_irq),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .desc_valid(desc_valid), .desc_data(desc_data), .desc_ready(desc_ready)
   );

   function automatic logic [31:0] word_at(input logic [31:0] a);
      return a ^ 32'hC0DE_0000;
   endfunction

   function automatic logic [127:0] desc_at(input logic [31:0] a);
      return {word_at(a + 32'd12), word_at(a + 32'd8), word_at(a + 32'd4), word_at(a)};
   endfunction

   task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // memory responder: acknowledges every other cycle while enabled
   always @(posedge clk) begin
      mem_ack   <= mem_req && !mem_ack && ack_en;
      mem_rdata <= word_at(mem_addr);
   end

   // monitor: 1 ns after the falling edge, inputs for the next edge are settled
   always @(negedge clk) begin
      #1;
      if (suspend_irq) begin
         irq_cnt++;
         if (irq_prev) chk("R10 pulse width", 1, 0);
      end
      irq_prev = suspend_irq;
      if (mem_req && mem_ack && ack_n < 16) begin
         ack_log[ack_n] = mem_addr;
         ack_n++;
      end
      if (desc_valid && desc_ready) begin
         chk("R4 descriptor words", desc_data, desc_at(cur_ptr));
         acc_cnt++;
      end
   end

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      reg_wr_en   = 1'b1;
      reg_wr_sel  = sel;
      reg_wr_data = d;
      @(negedge clk);
      reg_wr_en   = 1'b0;
   endtask

   task automatic wait_idle();
      int g = 0;
      repeat (2) @(negedge clk);
      while (running && g < 3000) begin
         @(negedge clk);
         g++;
      end
      if (g >= 3000) chk("R5 engine never suspended", 1, 0);
      repeat (2) @(negedge clk);
   endtask

   // {tail index, descriptors expected, final index}; ring of 8 at 0x1000
   localparam logic [23:0] VEC [5] = '{
      {8'd5, 8'd3, 8'd5},
      {8'd5, 8'd0, 8'd5},
      {8'd7, 8'd2, 8'd7},
      {8'd2, 8'd3, 8'd2},
      {8'd1, 8'd7, 8'd1}
   };

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int irq0, acc0;
      logic [127:0] cap;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 cur_ptr", cur_ptr, 0);
      chk("R1 running", running, 0);
      chk("R1 mem_req", mem_req, 0);
      chk("R1 desc_valid", desc_valid, 0);
      chk("R1 suspend_irq", suspend_irq, 0);

      // R2/R10: configure, enable with nothing pending
      wr(2'd0, 32'h1000);
      wr(2'd1, 32'd7);
      wr(2'd2, 32'h1000);
      wr(2'd3, 32'd1);
      repeat (4) @(negedge clk);
      chk("R10 irq on enable with no work", irq_cnt, 1);
      chk("R11 running low when suspended", running, 0);
      chk("R2 cur_ptr at base", cur_ptr, 32'h1000);

      // R3/R7: read handshake with stalled memory
      ack_en = 1'b0;
      wr(2'd2, 32'h1010);
      chk("R7 req the cycle after tail write", mem_req, 1);
      chk("R3 first read address", mem_addr, 32'h1000);
      chk("R11 running while fetching", running, 1);
      repeat (3) @(negedge clk);
      chk("R3 req held without ack", mem_req, 1);
      chk("R3 address held without ack", mem_addr, 32'h1000);
      ack_n = 0;
      acc0 = acc_cnt;
      ack_en = 1'b1;
      wait_idle();
      chk("R3 four reads", ack_n, 4);
      for (int i = 0; i < 4; i++) chk("R3 read address", ack_log[i], 32'h1000 + 4 * i);
      chk("R4 one descriptor accepted", acc_cnt - acc0, 1);
      chk("R4 pointer advanced", cur_ptr, 32'h1010);
      chk("R10 irq after catching up", irq_cnt, 2);

      // R4: back-pressure from the consumer
      desc_ready = 1'b0;
      wr(2'd2, 32'h1020);
      for (int g = 0; g < 100 && !desc_valid; g++) @(negedge clk);
      cap = desc_data;
      chk("R4 word order", cap, desc_at(32'h1010));
      repeat (5) @(negedge clk);
      chk("R4 valid held", desc_valid, 1);
      chk("R4 data held", desc_data, cap);
      chk("R4 pointer waits for accept", cur_ptr, 32'h1010);
      desc_ready = 1'b1;
      wait_idle();
      chk("R4 pointer after accept", cur_ptr, 32'h1020);

      // R5-R8: table of tail moves
      for (int i = 0; i < 5; i++) begin
         irq0 = irq_cnt;
         acc0 = acc_cnt;
         wr(2'd2, 32'h1000 + 32'd16 * 32'(VEC[i][23:16]));
         wait_idle();
         chk("R5 descriptors fetched", acc_cnt - acc0, 32'(VEC[i][15:8]));
         chk("R6 final pointer", cur_ptr, 32'h1000 + 32'd16 * 32'(VEC[i][7:0]));
         chk("R8 irq count per tail move", irq_cnt - irq0, (VEC[i][15:8] != 0) ? 1 : 0);
         chk("R11 running low at rest", running, 0);
      end

      // R9: base and length writes ignored while active
      wr(2'd0, 32'h8000);
      wr(2'd1, 32'd1);
      chk("R9 base write ignored", cur_ptr, 32'h1010);
      acc0 = acc_cnt;
      wr(2'd2, 32'h1040);
      wait_idle();
      chk("R9 length write ignored", acc_cnt - acc0, 3);
      chk("R9 pointer with old ring", cur_ptr, 32'h1040);

      // R9: disable clears index, config accepted while disabled
      wr(2'd3, 32'd0);
      repeat (3) @(negedge clk);
      chk("R11 running low when disabled", running, 0);
      chk("R9 disable returns to base", cur_ptr, 32'h1000);
      wr(2'd0, 32'h2007);
      chk("R2 base low bits dropped", cur_ptr, 32'h2000);
      wr(2'd1, 32'd1);
      wr(2'd2, 32'h2000);
      irq0 = irq_cnt;
      wr(2'd3, 32'd1);
      repeat (4) @(negedge clk);
      chk("R10 irq on re-enable", irq_cnt - irq0, 1);
      acc0 = acc_cnt;
      wr(2'd2, 32'h2010);
      wait_idle();
      chk("R9 new base used", cur_ptr, 32'h2010);
      wr(2'd2, 32'h2000);
      wait_idle();
      chk("R6 wrap with new length", cur_ptr, 32'h2000);
      chk("R6 two descriptors", acc_cnt - acc0, 2);

      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule